// File: doc/BRIEF.md
# Switchable-Width Byte-Lane Static Memory

A clocked static memory whose control decode follows that of an asynchronous SRAM with a selectable data width. One storage array of `DEPTH` 16-bit words is reached either as words, with a separate enable for each byte lane, or as `2*DEPTH` bytes. In byte mode an extra address input below the word address picks the half of the stored word, and all byte data moves on the low lane.

There are two chip enables of opposite polarity, an active-low output enable, an active-low write enable and two active-low byte-lane enables. Controls are sampled on the rising clock edge. Writes take effect at that edge. Read data and the per-lane drive flags come out of registers one clock later. The bidirectional data bus is split into an input bus and an output bus. A two-bit lane flag stands in for the tri-state control of each byte lane. A lane whose flag is low carries zero data.

Top module: `sram_lane_core`

## Requirements
- R1: The block is selected only when `ce1_ni` is 0 and `ce2_i` is 1. While it is unselected no write occurs and, one cycle later, `lane_oe_o` is 2'b00.
- R2: In word mode (`wide_i`=1), when `lb_ni` and `ub_ni` are both 1 the block is unselected: no write occurs and `lane_oe_o` is 2'b00 the next cycle.
- R3: A word-mode read (selected, `we_ni`=1, `oe_ni`=0) sets `lane_oe_o` = {~`ub_ni`, ~`lb_ni`} one cycle after sampling. `rdata_o` then holds the stored word at `addr_i` on the enabled lanes.
- R4: A write (selected, `we_ni`=0) occurs whatever the value of `oe_ni`. In word mode it updates bits 7:0 when `lb_ni`=0 and bits 15:8 when `ub_ni`=0, and leaves the other lane unchanged. The cycle after a write, `lane_oe_o` is 2'b00.
- R5: In byte mode (`wide_i`=0) the byte address is {`addr_i`, `sub_i`}. `sub_i`=0 names bits 7:0 of the stored word and `sub_i`=1 names bits 15:8. A byte write takes its data from `wdata_i[7:0]`. A byte read returns the byte on `rdata_o[7:0]` with `lane_oe_o`=2'b01 and never drives the upper lane.
- R6: In byte mode `lb_ni` and `ub_ni` have no effect, including when both are 1.
- R7: Selected with `we_ni`=1 and `oe_ni`=1 (output disable), no write occurs and `lane_oe_o` is 2'b00 the next cycle.
- R8: In word mode `sub_i` has no effect on reads or writes.
- R9: While `rst_ni` is 0, `rdata_o` and `lane_oe_o` are 0.
- R10: Any byte lane of `rdata_o` whose `lane_oe_o` flag is 0 reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; controls sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the output registers |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| lb_ni | input | 1 | Low byte lane enable, active low (word mode) |
| ub_ni | input | 1 | High byte lane enable, active low (word mode) |
| wide_i | input | 1 | 1: 16-bit word mode, 0: 8-bit byte mode |
| addr_i | input | $clog2(DEPTH) | Word address |
| sub_i | input | 1 | Byte address bit below `addr_i` (byte mode only) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| lane_oe_o | output | 2 | Per-lane drive flag: bit 0 low lane, bit 1 high lane |

## Verification
A wrong lane write mask or a wrong half-word select corrupts storage without any sign at the ports until that address is read back. The bench therefore reads every disturbed location again, in both word and byte views, and compares it against its own reference array. A wrong decode of select, output disable or mode shows in `lane_oe_o` or in zero-versus-data lanes exactly one cycle after the offending sample. A stale or mis-timed output register shows as data shifted by one operation in the scoreboard order.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_lane_dec.sv
module sram_lane_dec
  import sram_lane_pkg::*;
(
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             oe_ni,
  input  logic             we_ni,
  input  logic             lb_ni,
  input  logic             ub_ni,
  input  logic             wide_i,
  input  logic             sub_i,
  output op_e              op_o,
  output logic [LANES-1:0] bank_we_o,
  output logic [LANES-1:0] rd_mask_o
);
  logic             chip_on;
  logic             sel;
  logic [LANES-1:0] lane_req;

  assign chip_on = !ce1_ni && ce2_i;
  // byte enables only deselect in word mode
  assign sel = chip_on && (!wide_i || !(lb_ni && ub_ni));

  always_comb begin
    if (!sel)       op_o = OP_IDLE;
    else if (!we_ni) op_o = OP_WRITE;
    else if (!oe_ni) op_o = OP_READ;
    else            op_o = OP_IDLE;
  end

  assign lane_req = wide_i ? {!ub_ni, !lb_ni} : {sub_i, !sub_i};

  assign bank_we_o = (op_o == OP_WRITE) ? lane_req : '0;
  assign rd_mask_o = (op_o != OP_READ) ? '0 :
                     (wide_i ? {!ub_ni, !lb_ni} : {1'b0, 1'b1});
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANE_W-1:0] din_i,
  output logic [LANE_W-1:0] dout_o
);
  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= din_i;
  end

  assign dout_o = mem_q[addr_i];
endmodule

// File: rtl/sram_lane_rdout.sv
module sram_lane_rdout
  import sram_lane_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  rd_mask_i,
  input  logic              byte_mode_i,
  input  logic              sub_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0]  lane_oe_o
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (byte_mode_i) begin
      if (rd_mask_i[0])
        rdata_d[LANE_W-1:0] = word_i[sub_i*LANE_W +: LANE_W];
    end else begin
      for (int l = 0; l < LANES; l++)
        if (rd_mask_i[l]) rdata_d[l*LANE_W +: LANE_W] = word_i[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      lane_oe_o <= '0;
    end else begin
      rdata_o   <= rdata_d;
      lane_oe_o <= rd_mask_i;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_zero_chk
    a_r10_idle_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lane_oe_o[l] |-> rdata_o[l*LANE_W +: LANE_W] == '0);
  end
endmodule

// File: rtl/sram_lane_core.sv
module sram_lane_core
  import sram_lane_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              lb_ni,
  input  logic              ub_ni,
  input  logic              wide_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              sub_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0]  lane_oe_o
);
  op_e               op;
  logic [LANES-1:0]  bank_we;
  logic [LANES-1:0]  rd_mask;
  logic [DATA_W-1:0] word_rd;

  sram_lane_dec i_dec (
    .ce1_ni    (ce1_ni),
    .ce2_i     (ce2_i),
    .oe_ni     (oe_ni),
    .we_ni     (we_ni),
    .lb_ni     (lb_ni),
    .ub_ni     (ub_ni),
    .wide_i    (wide_i),
    .sub_i     (sub_i),
    .op_o      (op),
    .bank_we_o (bank_we),
    .rd_mask_o (rd_mask)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    logic [LANE_W-1:0] din;
    // byte mode steers the low data lane to every bank
    assign din = wide_i ? wdata_i[l*LANE_W +: LANE_W] : wdata_i[LANE_W-1:0];

    sram_lane_bank #(.DEPTH(DEPTH), .LANE_W(LANE_W)) i_bank (
      .clk_i  (clk_i),
      .we_i   (bank_we[l]),
      .addr_i (addr_i),
      .din_i  (din),
      .dout_o (word_rd[l*LANE_W +: LANE_W])
    );

    a_r5_byte_write_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wide_i && bank_we[l]) |-> (sub_i == (l == 1)));
  end

  sram_lane_rdout i_rdout (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_mask_i   (rd_mask),
    .byte_mode_i (!wide_i),
    .sub_i       (sub_i),
    .word_i      (word_rd),
    .rdata_o     (rdata_o),
    .lane_oe_o   (lane_oe_o)
  );

  a_r1_unselected_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce1_ni || !ce2_i) |=> lane_oe_o == '0);
  a_r1_unselected_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce1_ni || !ce2_i) |-> bank_we == '0);
  a_r2_no_lane_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && lb_ni && ub_ni) |=> lane_oe_o == '0);
  a_r3_word_read_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce1_ni && ce2_i && we_ni && !oe_ni && wide_i) |=> lane_oe_o == ~$past({ub_ni, lb_ni}));
  a_r4_write_not_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce1_ni && ce2_i && !we_ni) |=> lane_oe_o == '0);
  a_r5_byte_low_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |=> !lane_oe_o[1]);
  a_r7_output_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_ni && oe_ni) |=> lane_oe_o == '0);
endmodule

// File: tb/test_sram_lane_core.sv
module test_sram_lane_core;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned AW    = $clog2(DEPTH);

  typedef struct {
    logic [15:0] data;
    logic [1:0]  oe;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce1_ni = 1'b1, ce2_i = 1'b0, oe_ni = 1'b1, we_ni = 1'b1;
  logic          lb_ni = 1'b1, ub_ni = 1'b1, wide_i = 1'b1, sub_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   wdata_i = '0;
  logic [15:0]   rdata_o;
  logic [1:0]    lane_oe_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [15:0] ref_mem [DEPTH];

  always #2 clk = ~clk;

  sram_lane_core #(.DEPTH(DEPTH)) i_sram_lane_core (
    .clk_i(clk), .rst_ni(rst_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i),
    .oe_ni(oe_ni), .we_ni(we_ni), .lb_ni(lb_ni), .ub_ni(ub_ni),
    .wide_i(wide_i), .addr_i(addr_i), .sub_i(sub_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .lane_oe_o(lane_oe_o)
  );

  task automatic check(input logic [15:0] d, input logic [1:0] o, input exp_t e);
    checks++;
    if (d !== e.data || o !== e.oe) begin
      errors++;
      $display("FAIL %s: got data %h lanes %b, expected data %h lanes %b",
               e.tag, d, o, e.data, e.oe);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) check(rdata_o, lane_oe_o, q.pop_front());
    end
  end

  // driver: one access per clock, expected result from the reference array
  task automatic op(input logic c1, c2, oe, we, lb, ub, wd,
                    input logic [AW-1:0] a, input logic s,
                    input logic [15:0] d, input string tag);
    exp_t e;
    logic sel;
    @(negedge clk);
    ce1_ni = c1; ce2_i = c2; oe_ni = oe; we_ni = we;
    lb_ni = lb; ub_ni = ub; wide_i = wd; addr_i = a; sub_i = s; wdata_i = d;
    e.data = '0; e.oe = 2'b00; e.tag = tag;
    sel = !c1 && c2 && (!wd || !(lb && ub));
    if (sel && !we) begin
      if (wd) begin
        if (!lb) ref_mem[a][7:0]  = d[7:0];
        if (!ub) ref_mem[a][15:8] = d[15:8];
      end else if (s) ref_mem[a][15:8] = d[7:0];
      else            ref_mem[a][7:0]  = d[7:0];
    end else if (sel && !oe) begin
      if (wd) begin
        e.oe = {!ub, !lb};
        e.data = {ub ? 8'h00 : ref_mem[a][15:8], lb ? 8'h00 : ref_mem[a][7:0]};
      end else begin
        e.oe = 2'b01;
        e.data = {8'h00, s ? ref_mem[a][15:8] : ref_mem[a][7:0]};
      end
    end
    q.push_back(e);
  endtask

  task automatic wr_w(input logic [AW-1:0] a, input logic lb, ub, oe, s,
                      input logic [15:0] d, input string tag);
    op(1'b0, 1'b1, oe, 1'b0, lb, ub, 1'b1, a, s, d, tag);
  endtask
  task automatic rd_w(input logic [AW-1:0] a, input logic lb, ub, s, input string tag);
    op(1'b0, 1'b1, 1'b0, 1'b1, lb, ub, 1'b1, a, s, 16'hdead, tag);
  endtask
  task automatic wr_b(input logic [AW-1:0] a, input logic s, lb, ub,
                      input logic [15:0] d, input string tag);
    op(1'b0, 1'b1, 1'b1, 1'b0, lb, ub, 1'b0, a, s, d, tag);
  endtask
  task automatic rd_b(input logic [AW-1:0] a, input logic s, lb, ub, input string tag);
    op(1'b0, 1'b1, 1'b0, 1'b1, lb, ub, 1'b0, a, s, 16'hbeef, tag);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t e0;
    repeat (3) @(negedge clk);
    e0.data = '0; e0.oe = 2'b00; e0.tag = "R9 reset";
    check(rdata_o, lane_oe_o, e0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < DEPTH; i++)
      wr_w(AW'(i), 1'b0, 1'b0, 1'b1, 1'b0, 16'h1000 + 16'(i * 16'h0101), "R4 fill");
    rd_w(AW'(3), 1'b0, 1'b0, 1'b0, "R3 both lanes");
    rd_w(AW'(4), 1'b0, 1'b1, 1'b0, "R3 R10 low lane");
    rd_w(AW'(5), 1'b1, 1'b0, 1'b0, "R3 R10 high lane");

    wr_w(AW'(7), 1'b0, 1'b1, 1'b0, 1'b0, 16'haa55, "R4 low only oe low");
    wr_w(AW'(8), 1'b1, 1'b0, 1'b1, 1'b0, 16'h33cc, "R4 high only");
    rd_w(AW'(7), 1'b0, 1'b0, 1'b0, "R4 low lane kept");
    rd_w(AW'(8), 1'b0, 1'b0, 1'b0, "R4 high lane kept");

    op(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, AW'(9), 1'b0, 16'hffff, "R1 ce1 off write");
    op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, AW'(9), 1'b0, 16'heeee, "R1 ce2 off write");
    op(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, AW'(9), 1'b0, 16'h0, "R1 off read");
    wr_w(AW'(9), 1'b1, 1'b1, 1'b1, 1'b0, 16'h7777, "R2 no lanes write");
    rd_w(AW'(9), 1'b1, 1'b1, 1'b0, "R2 no lanes read");
    rd_w(AW'(9), 1'b0, 1'b0, 1'b0, "R1 R2 unchanged");

    op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, AW'(9), 1'b0, 16'h0, "R7 output disable");
    op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, AW'(9), 1'b1, 16'h0, "R7 byte disable");

    wr_b(AW'(10), 1'b0, 1'b1, 1'b1, 16'hff12, "R5 R6 byte low write");
    wr_b(AW'(10), 1'b1, 1'b1, 1'b1, 16'hff34, "R5 R6 byte high write");
    rd_w(AW'(10), 1'b0, 1'b0, 1'b0, "R5 word view");
    rd_b(AW'(10), 1'b0, 1'b1, 1'b1, "R5 R6 byte read low");
    rd_b(AW'(10), 1'b1, 1'b0, 1'b0, "R5 R6 byte read high");
    wr_b(AW'(11), 1'b1, 1'b0, 1'b1, 16'h00ab, "R6 byte write lb");
    rd_w(AW'(11), 1'b0, 1'b0, 1'b0, "R5 R6 half select");

    rd_w(AW'(12), 1'b0, 1'b0, 1'b1, "R8 sub on read");
    wr_w(AW'(12), 1'b0, 1'b0, 1'b1, 1'b1, 16'h5a5a, "R8 sub on write");
    rd_w(AW'(12), 1'b0, 1'b0, 1'b0, "R8 readback");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0] & r[1], !(r[2] & r[3]), r[4], r[5] & r[6], r[7], r[8], r[9],
         AW'(r[31:16]), r[10], 16'($urandom), "R3/R4/R5/R6/R8 mix");
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule